// File: doc/BRIEF.md
# Debug Command Frame Sequencer

This block runs the command level of a single-wire debug link. It works on top of a bit-level transceiver, which it drives one field at a time. It first asks the transceiver for an 8-bit command field and decodes the command class from it. It then requests the address and data fields the class needs, or hands a 16-bit result back for transmission to the host. Between fields it holds a mandatory pause. The pause is counted in bus-clock ticks, and the memory access belonging to the command is carried out during it.

The command classes are as follows:
- hardware-space read and write, which carry a 16-bit address;
- firmware-space read and write, which take a small register index from the low bits of the command byte;
- go and trace, which only emit a one-cycle pulse and then pause.

A timeout reported by the transceiver abandons the frame at any stage. An opcode outside the classes is dropped.

Top module: `dbg_frame_seq`

## Requirements
- R1: One cycle after reset is released, and again after every frame ends, the block pulses `xcv_start` with `xcv_len`=8 and `xcv_dir`=0 (receive a command byte).
- R2: Command byte decoding: bits[7:6]=10 is a hardware read; 11 is a hardware write; bits[7:5]=011 is a firmware read; 010 is a firmware write; 0x08 is go; 0x10 is trace. For firmware commands, bits[2:0] form the register index, presented zero-extended on `mem_addr` with `mem_fw`=1.
- R3: Hardware read has the field order command, 16-bit address field, pause of 150 ticks with a memory read of that address, then a 16-bit send field (`xcv_dir`=1) whose `xcv_txdata` is the read data.
- R4: Hardware write has the field order command, 16-bit address, 16-bit data, then a memory write of that data to that address inside a pause of 150 ticks.
- R5: Firmware read has the field order command, then a pause of 44 ticks with a firmware-space read, then a 16-bit send field carrying the read data.
- R6: Firmware write has the field order command, 16-bit data, then a pause of 32 ticks with a firmware-space write.
- R7: Go and trace each raise `go_pulse` or `trace_pulse` for exactly one cycle at the start of a 64-tick pause. They perform no memory access.
- R8: A pause of N ticks ends so that exactly N `bus_tick` pulses fall between the cycle that consumed the field's `xcv_done` and the next `xcv_start`, when memory answers in time. Ticks are taken one every third cycle or sparser.
- R9: `mem_req` stays high, with `mem_addr`, `mem_we` and `mem_wdata` stable, until `mem_ready` is seen. If the access has not completed when the count expires, the next field waits for it.
- R10: `xcv_timeout` in any state makes the next cycle issue a fresh command field and drops any pending memory request.
- R11: A command byte outside the R2 classes causes no memory access and no pulse, and is followed directly by a new command field.
- R12: `xcv_start` is a single-cycle pulse, and a new field is never started while one is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_tick | input | 1 | One-cycle bus-clock tick used for pause counting |
| xcv_start | output | 1 | Starts one transceiver field |
| xcv_len | output | 5 | Field length in bits (8 or 16) |
| xcv_dir | output | 1 | 0 receive from host, 1 send to host |
| xcv_txdata | output | 16 | Data for a send field |
| xcv_rxdata | input | 16 | Data of a received field, valid with `xcv_done` |
| xcv_done | input | 1 | Field completed |
| xcv_timeout | input | 1 | Link timed out |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 write, 0 read |
| mem_fw | output | 1 | Selects firmware register space |
| mem_addr | output | 16 | Access address or register index |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid with `mem_ready` |
| mem_ready | input | 1 | Access accepted and complete |
| go_pulse | output | 1 | Go command pulse |
| trace_pulse | output | 1 | Trace command pulse |

## Verification
The assertions check the following on every cycle:
- the memory request stays held and stable until it is accepted;
- the transceiver is never started during an access;
- start is a single-cycle pulse, and a send is always 16 bits;
- a timeout or a completed send is always followed by a fresh command field;
- go and trace never overlap an access.

Only the bench scenarios can show the remaining behaviour:
- field order per class;
- exact tick counts of each pause;
- the read data returning to the host;
- the stall when memory is slow;
- dropping of unknown opcodes.

// File: rtl/dbg_frame_seq.sv
module dbg_frame_seq #(
  parameter int CMD_W    = 8,
  parameter int FLD_W    = 16,
  parameter int LEN_W    = 5,
  parameter int DLY_W    = 8,
  parameter int IDX_W    = 3,
  parameter int HWR_DLY  = 150,
  parameter int HWW_DLY  = 150,
  parameter int FWR_DLY  = 44,
  parameter int FWW_DLY  = 32,
  parameter int RUN_DLY  = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_tick,
  output logic             xcv_start,
  output logic [LEN_W-1:0] xcv_len,
  output logic             xcv_dir,
  output logic [FLD_W-1:0] xcv_txdata,
  input  logic [FLD_W-1:0] xcv_rxdata,
  input  logic             xcv_done,
  input  logic             xcv_timeout,
  output logic             mem_req,
  output logic             mem_we,
  output logic             mem_fw,
  output logic [FLD_W-1:0] mem_addr,
  output logic [FLD_W-1:0] mem_wdata,
  input  logic [FLD_W-1:0] mem_rdata,
  input  logic             mem_ready,
  output logic             go_pulse,
  output logic             trace_pulse
);
  localparam logic [2:0] C_NONE = 3'd0, C_HWR = 3'd1, C_HWW = 3'd2,
                         C_FWR = 3'd3, C_FWW = 3'd4, C_GO = 3'd5, C_TRC = 3'd6;

  typedef enum logic [2:0] {S_CMD, S_ADDR, S_WDATA, S_DLY, S_RDATA} st_t;

  st_t              state, nxt;
  logic [2:0]       cls, dec, cls_eff;
  logic [IDX_W-1:0] fw_idx;
  logic [FLD_W-1:0] addr_r, wdata_r, rdbuf;
  logic [DLY_W-1:0] dly_cnt;
  logic             acc_done, launch, started, go_r, trc_r;
  logic             need_acc, dly_end, advance, enter_dly, rx_ok;

  wire [CMD_W-1:0] op = xcv_rxdata[CMD_W-1:0];

  always_comb begin
    if (op[CMD_W-1 -: 2] == 2'b10)      dec = C_HWR;
    else if (op[CMD_W-1 -: 2] == 2'b11) dec = C_HWW;
    else if (op[CMD_W-1 -: 3] == 3'b011) dec = C_FWR;
    else if (op[CMD_W-1 -: 3] == 3'b010) dec = C_FWW;
    else if (op == CMD_W'(8'h08))       dec = C_GO;
    else if (op == CMD_W'(8'h10))       dec = C_TRC;
    else                                 dec = C_NONE;
  end

  function automatic logic [DLY_W-1:0] dly_of(input logic [2:0] c);
    case (c)
      C_HWR:   dly_of = DLY_W'(HWR_DLY);
      C_HWW:   dly_of = DLY_W'(HWW_DLY);
      C_FWR:   dly_of = DLY_W'(FWR_DLY);
      C_FWW:   dly_of = DLY_W'(FWW_DLY);
      default: dly_of = DLY_W'(RUN_DLY);
    endcase
  endfunction

  assign cls_eff  = (state == S_CMD) ? dec : cls;
  assign need_acc = (cls == C_HWR) || (cls == C_HWW) || (cls == C_FWR) || (cls == C_FWW);
  assign rx_ok    = xcv_done && !xcv_timeout;
  assign dly_end  = (state == S_DLY) && (dly_cnt == '0) && (acc_done || !need_acc);
  assign advance  = xcv_timeout || (xcv_done && state != S_DLY) || dly_end;

  always_comb begin
    nxt = state;
    if (xcv_timeout) nxt = S_CMD;
    else begin
      case (state)
        S_CMD: if (xcv_done) begin
          case (dec)
            C_HWR, C_HWW:        nxt = S_ADDR;
            C_FWW:               nxt = S_WDATA;
            C_FWR, C_GO, C_TRC:  nxt = S_DLY;
            default:             nxt = S_CMD;
          endcase
        end
        S_ADDR:  if (xcv_done) nxt = (cls == C_HWW) ? S_WDATA : S_DLY;
        S_WDATA: if (xcv_done) nxt = S_DLY;
        S_DLY:   if (dly_end) nxt = (cls == C_HWR || cls == C_FWR) ? S_RDATA : S_CMD;
        S_RDATA: if (xcv_done) nxt = S_CMD;
        default: nxt = S_CMD;
      endcase
    end
  end

  assign enter_dly = !xcv_timeout && nxt == S_DLY && state != S_DLY;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_CMD;
      cls      <= C_NONE;
      fw_idx   <= '0;
      addr_r   <= '0;
      wdata_r  <= '0;
      rdbuf    <= '0;
      dly_cnt  <= '0;
      acc_done <= 1'b0;
      launch   <= 1'b0;
      started  <= 1'b0;
      go_r     <= 1'b0;
      trc_r    <= 1'b0;
    end else begin
      started <= 1'b1;
      launch  <= !started || (advance && nxt != S_DLY);
      state   <= nxt;
      go_r    <= enter_dly && cls_eff == C_GO;
      trc_r   <= enter_dly && cls_eff == C_TRC;
      if (state == S_CMD && rx_ok) begin
        cls    <= dec;
        fw_idx <= op[IDX_W-1:0];
      end
      if (state == S_ADDR && rx_ok)  addr_r  <= xcv_rxdata;
      if (state == S_WDATA && rx_ok) wdata_r <= xcv_rxdata;
      if (enter_dly) begin
        dly_cnt  <= dly_of(cls_eff);
        acc_done <= 1'b0;
      end else if (state == S_DLY) begin
        if (bus_tick && dly_cnt != '0) dly_cnt <= dly_cnt - 1'b1;
        if (mem_req && mem_ready) begin
          acc_done <= 1'b1;
          rdbuf    <= mem_rdata;
        end
      end
    end
  end

  assign xcv_start   = launch;
  assign xcv_len     = (state == S_CMD) ? LEN_W'(CMD_W) : LEN_W'(FLD_W);
  assign xcv_dir     = (state == S_RDATA);
  assign xcv_txdata  = rdbuf;
  assign mem_req     = (state == S_DLY) && need_acc && !acc_done;
  assign mem_we      = (cls == C_HWW) || (cls == C_FWW);
  assign mem_fw      = (cls == C_FWR) || (cls == C_FWW);
  assign mem_addr    = mem_fw ? {{(FLD_W-IDX_W){1'b0}}, fw_idx} : addr_r;
  assign mem_wdata   = wdata_r;
  assign go_pulse    = go_r;
  assign trace_pulse = trc_r;
endmodule

module dbg_frame_seq_chk #(
  parameter int LEN_W = 5,
  parameter int FLD_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             xcv_start,
  input logic [LEN_W-1:0] xcv_len,
  input logic             xcv_dir,
  input logic             xcv_done,
  input logic             xcv_timeout,
  input logic             mem_req,
  input logic             mem_we,
  input logic [FLD_W-1:0] mem_addr,
  input logic [FLD_W-1:0] mem_wdata,
  input logic             mem_ready,
  input logic             go_pulse,
  input logic             trace_pulse
);
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ready && !xcv_timeout |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)); // R9
  AST_NO_START_IN_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !xcv_start); // R9
  AST_TIMEOUT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    xcv_timeout |=> xcv_start && xcv_len == LEN_W'(8) && !xcv_dir && !mem_req); // R10
  AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    xcv_start |=> !xcv_start); // R12
  AST_SEND_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    xcv_start && xcv_dir |-> xcv_len == LEN_W'(16)); // R3
  AST_CMD_AFTER_SEND: assert property (@(posedge clk) disable iff (!rst_n)
    xcv_done && xcv_dir && !xcv_timeout |=> xcv_start && xcv_len == LEN_W'(8) && !xcv_dir); // R1
  AST_PULSE_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    (go_pulse || trace_pulse) |-> !mem_req && !(go_pulse && trace_pulse)); // R7
endmodule

bind dbg_frame_seq dbg_frame_seq_chk #(.LEN_W(LEN_W), .FLD_W(FLD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .xcv_start(xcv_start), .xcv_len(xcv_len), .xcv_dir(xcv_dir),
  .xcv_done(xcv_done), .xcv_timeout(xcv_timeout), .mem_req(mem_req), .mem_we(mem_we),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ready(mem_ready),
  .go_pulse(go_pulse), .trace_pulse(trace_pulse));

// File: tb/sim_dbg_frame_seq.sv
module sim_dbg_frame_seq;
  logic        clk = 1'b0, rst_n = 1'b0, bus_tick = 1'b0;
  logic        xcv_start, xcv_dir, xcv_done = 1'b0, xcv_timeout = 1'b0;
  logic [4:0]  xcv_len;
  logic [15:0] xcv_txdata, xcv_rxdata = '0;
  logic        mem_req, mem_we, mem_fw, mem_ready = 1'b0;
  logic [15:0] mem_addr, mem_wdata, mem_rdata = '0;
  logic        go_pulse, trace_pulse;

  always #2.5 clk = ~clk;

  dbg_frame_seq u0 (
    .clk(clk), .rst_n(rst_n), .bus_tick(bus_tick),
    .xcv_start(xcv_start), .xcv_len(xcv_len), .xcv_dir(xcv_dir), .xcv_txdata(xcv_txdata),
    .xcv_rxdata(xcv_rxdata), .xcv_done(xcv_done), .xcv_timeout(xcv_timeout),
    .mem_req(mem_req), .mem_we(mem_we), .mem_fw(mem_fw), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
    .go_pulse(go_pulse), .trace_pulse(trace_pulse));

  localparam int K_FLD = 0, K_MEM = 1, K_DLY = 2, K_DLYGT = 3, K_GO = 4, K_TRC = 5;
  typedef struct { int k; int a; int b; int c; int d; string r; } ev_t;

  ev_t exp_q[$];
  int  host_q[$];
  int  checks = 0, failures = 0;
  int  mem_lat = 0;
  bit  to_now = 0, to_f16 = 0, done_run = 0;

  function automatic int rd_val(input int a, input int fw);
    return fw ? (a ^ 16'hF000) : (a ^ 16'hA5C3);
  endfunction

  function automatic void push(input int k, input int a, input int b, input int c, input int d, input string r);
    ev_t e;
    e.k = k; e.a = a; e.b = b; e.c = c; e.d = d; e.r = r;
    exp_q.push_back(e);
  endfunction

  function automatic void take(input int k, input int a, input int b, input int c, input int d, input string what);
    ev_t e;
    checks++;
    if (exp_q.size() == 0) begin
      failures++;
      $display("FAIL unexpected %s act=(%0h,%0h,%0h,%0h) exp=none", what, a, b, c, d);
      return;
    end
    e = exp_q.pop_front();
    if (e.k != k || e.a != a || e.b != b || (e.c >= 0 && e.c != c) || e.d != d) begin
      failures++;
      $display("FAIL %s %s act=(k%0d %0h,%0h,%0h,%0h) exp=(k%0d %0h,%0h,%0h,%0h)",
               e.r, what, k, a, b, c, d, e.k, e.a, e.b, e.c, e.d);
    end
  endfunction

  // bus tick every third cycle
  initial begin
    int t = 0;
    forever begin
      @(negedge clk);
      bus_tick = (t == 2);
      t = (t + 1) % 3;
    end
  end

  // host side of the transceiver
  initial begin
    int hbusy = 0, hwait = 0, hlen = 0, hdir = 0;
    forever begin
      @(negedge clk);
      xcv_done = 1'b0;
      xcv_timeout = 1'b0;
      if (!rst_n) hbusy = 0;
      else if (to_now) begin
        xcv_timeout = 1'b1; to_now = 0; hbusy = 0;
      end else begin
        if (hbusy != 0 && hwait > 0) hwait--;
        else if (hbusy != 0) begin
          if (to_f16 && hlen == 16 && hdir == 0) begin
            xcv_timeout = 1'b1; to_f16 = 0; hbusy = 0;
          end else if (hdir == 1) begin
            xcv_done = 1'b1; hbusy = 0;
          end else if (host_q.size() > 0) begin
            xcv_rxdata = 16'(host_q.pop_front()); xcv_done = 1'b1; hbusy = 0;
          end
        end
        if (xcv_start) begin
          checks++;
          if (hbusy != 0) begin
            failures++;
            $display("FAIL R12 start while field busy act=1 exp=0");
          end
          hbusy = 1; hwait = 3; hlen = int'(xcv_len); hdir = int'(xcv_dir);
        end
      end
    end
  end

  // memory model, records accesses at the moment it accepts them
  initial begin
    int mcnt = 0;
    forever begin
      @(negedge clk);
      mem_ready = 1'b0;
      if (mem_req) begin
        if (mcnt >= mem_lat) begin
          mem_ready = 1'b1;
          mem_rdata = 16'(rd_val(int'(mem_addr), int'(mem_fw)));
          take(K_MEM, int'(mem_addr), int'(mem_we), int'(mem_wdata), int'(mem_fw), "mem");
          mcnt = 0;
        end else mcnt++;
      end else mcnt = 0;
    end
  end

  // monitor: fields, pauses, pulses
  initial begin
    int ticks = 0, cyc = 0;
    forever begin
      @(posedge clk); #1;
      cyc++;
      if (cyc > 150000 && !done_run) begin
        failures++;
        $display("FAIL watchdog expired act=%0d exp<150000", cyc);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
      if (rst_n) begin
        if (go_pulse)    take(K_GO, 1, 0, 0, 0, "go");
        if (trace_pulse) take(K_TRC, 1, 0, 0, 0, "trace");
        if (xcv_done || xcv_timeout) ticks = 0;
        else if (!xcv_start && bus_tick) ticks++;
        if (xcv_start) begin
          if (exp_q.size() > 0 && exp_q[0].k == K_DLY) take(K_DLY, ticks, 0, 0, 0, "pause");
          else if (exp_q.size() > 0 && exp_q[0].k == K_DLYGT) begin
            checks++;
            if (ticks <= exp_q[0].a) begin
              failures++;
              $display("FAIL %s stalled pause act=%0d exp>%0d", exp_q[0].r, ticks, exp_q[0].a);
            end
            void'(exp_q.pop_front());
          end
          take(K_FLD, int'(xcv_len), int'(xcv_dir), int'(xcv_txdata), 0, "field");
        end
      end
    end
  end

  task automatic drain();
    while (exp_q.size() != 0) @(posedge clk);
    repeat (10) @(posedge clk);
  endtask

  task automatic fld(input int len, input int dir, input int tx, input string r);
    push(K_FLD, len, dir, tx, 0, r);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1;
    checks++;
    if (xcv_start || mem_req || go_pulse || trace_pulse) begin
      failures++;
      $display("FAIL R1 reset outputs act=%b%b%b%b exp=0000", xcv_start, mem_req, go_pulse, trace_pulse);
    end
    fld(8, 0, -1, "R1");
    @(negedge clk); rst_n = 1'b1;
    drain();

    // R3 hardware read
    host_q.push_back(8'h85); host_q.push_back(16'h1234);
    fld(16, 0, -1, "R3");
    push(K_MEM, 16'h1234, 0, -1, 0, "R3");
    push(K_DLY, 150, 0, 0, 0, "R3/R8");
    fld(16, 1, rd_val(16'h1234, 0), "R3");
    fld(8, 0, -1, "R1");
    drain();

    // R4 hardware write
    host_q.push_back(8'hC0); host_q.push_back(16'h00FF); host_q.push_back(16'hBEEF);
    fld(16, 0, -1, "R4"); fld(16, 0, -1, "R4");
    push(K_MEM, 16'h00FF, 1, 16'hBEEF, 0, "R4");
    push(K_DLY, 150, 0, 0, 0, "R4/R8");
    fld(8, 0, -1, "R4");
    drain();

    // R5 firmware read, index 5
    host_q.push_back(8'h65);
    push(K_MEM, 5, 0, -1, 1, "R5/R2");
    push(K_DLY, 44, 0, 0, 0, "R5/R8");
    fld(16, 1, rd_val(5, 1), "R5");
    fld(8, 0, -1, "R5");
    drain();

    // R6 firmware write, index 3
    host_q.push_back(8'h43); host_q.push_back(16'h1357);
    fld(16, 0, -1, "R6");
    push(K_MEM, 3, 1, 16'h1357, 1, "R6/R2");
    push(K_DLY, 32, 0, 0, 0, "R6/R8");
    fld(8, 0, -1, "R6");
    drain();

    // R7 go then trace
    host_q.push_back(8'h08);
    push(K_GO, 1, 0, 0, 0, "R7");
    push(K_DLY, 64, 0, 0, 0, "R7/R8");
    fld(8, 0, -1, "R7");
    host_q.push_back(8'h10);
    push(K_TRC, 1, 0, 0, 0, "R7");
    push(K_DLY, 64, 0, 0, 0, "R7/R8");
    fld(8, 0, -1, "R7");
    drain();

    // R11 unknown opcodes
    host_q.push_back(8'h20); fld(8, 0, -1, "R11");
    host_q.push_back(8'h09); fld(8, 0, -1, "R11");
    drain();

    // R9 slow memory stalls the pause
    mem_lat = 500;
    host_q.push_back(8'h80); host_q.push_back(16'h0042);
    fld(16, 0, -1, "R9");
    push(K_MEM, 16'h0042, 0, -1, 0, "R9");
    push(K_DLYGT, 150, 0, 0, 0, "R9");
    fld(16, 1, rd_val(16'h0042, 0), "R9");
    fld(8, 0, -1, "R9");
    drain();
    mem_lat = 0;

    // R10 timeout in the address field
    to_f16 = 1;
    host_q.push_back(8'h80);
    fld(16, 0, -1, "R10");
    fld(8, 0, -1, "R10");
    drain();

    // R10 timeout during a pause with a pending write
    mem_lat = 1000;
    host_q.push_back(8'hC0); host_q.push_back(16'h0010); host_q.push_back(16'h0001);
    fld(16, 0, -1, "R10"); fld(16, 0, -1, "R10");
    fld(8, 0, -1, "R10");
    while (exp_q.size() > 1) @(posedge clk);
    repeat (30) @(posedge clk);
    #2 to_now = 1;
    drain();
    mem_lat = 0;

    // recovery after timeouts: firmware read index 7
    host_q.push_back(8'h67);
    push(K_MEM, 7, 0, -1, 1, "R10/R5");
    push(K_DLY, 44, 0, 0, 0, "R8");
    fld(16, 1, rd_val(7, 1), "R5");
    fld(8, 0, -1, "R1");
    drain();

    checks++;
    if (exp_q.size() != 0) begin
      failures++;
      $display("FAIL R1 leftover events act=%0d exp=0", exp_q.size());
    end
    done_run = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule